// File: doc/BRIEF.md
# Two-Stage Cascaded Interrupt Controller

Two eight-input prioritising stages are chained so that a processor sees one interrupt wire for fifteen device lines. The secondary stage gathers lines 8 to 15 and feeds its request into input 2 of the primary stage, which serves lines 0 to 7. A device line 2 therefore does not exist. Each line catches rising edges and holds them as pending until the processor takes them. A pending line can be held back by its own mask bit or, for all lines together, by a global enable. Masked requests are kept, not dropped.

When an unblocked request is waiting, `irq_out` rises and `vector` shows the vector base plus the winning line number. A one-cycle `ack` pulse takes that line: its pending bit clears and its in-service bit sets. For a secondary line, the cascade input of the primary stage is also marked in service. End-of-interrupt commands are written separately to each stage. Each command clears that stage's highest-priority in-service bit, so a secondary-stage line needs one command to each stage. A small write port loads the masks, the base and the enable.

Top module: `cascade_intc`

## Requirements
- R1: After reset, `irq_out` is low, the global enable is off, all mask bits are clear and the vector base is 32.
- R2: A line becomes pending only on a 0-to-1 transition of its `irq_in` bit. A level that stays high raises no further request. `irq_in[2]` never has any effect.
- R3: Within each stage, the lower input number wins. All secondary lines (8..15) compete at the position of primary input 2, so line 1 beats line 8 and line 8 beats line 3.
- R4: With the enable off (register 3, bit 0 = 0), `irq_out` stays low and `ack` does nothing. Pending lines are kept and are presented once the enable returns.
- R5: Mask register 0 bit i holds back primary line i, and mask register 1 bit k holds back line 8+k. Primary mask bit 2 holds back the whole secondary stage. A masked line stays pending and is presented once it is unmasked.
- R6: While `irq_out` is high, `vector` equals the base (register 2) plus the line number, modulo 256.
- R7: An `ack` in a cycle with `irq_out` high clears the winning line's pending bit and sets its in-service bit at that clock edge. For lines 8..15 it also sets in-service on primary input 2. An `ack` while `irq_out` is low is ignored.
- R8: An in-service input blocks itself and all lower-priority inputs of its stage, while higher-priority inputs may still interrupt. A secondary line in service blocks the whole secondary stage through primary input 2.
- R9: A write to address 4 clears the highest-priority in-service bit of the primary stage, and a write to address 5 clears that of the secondary stage. Data is ignored in both cases. A secondary line is fully retired only after both writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 16 | Device request lines, bit 2 unused |
| ack | input | 1 | Processor acknowledge pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | 0 primary mask, 1 secondary mask, 2 base, 3 enable, 4 primary EOI, 5 secondary EOI |
| wr_data | input | 8 | Write data |
| irq_out | output | 1 | Interrupt request to processor |
| vector | output | 8 | Vector of the winning line |

## Verification
The hardest state to reach is a secondary line whose primary cascade bit has already been retired while its own secondary in-service bit is still set. In that state, higher secondary lines may interrupt again but lower ones must wait. The stimulus acknowledges line 10 and issues only the primary end-of-interrupt. It then raises line 11 and line 9 in turn, and only afterwards issues the secondary command. A long random phase then mixes edges, masks, acknowledges and both end-of-interrupt commands against the cycle model.

// File: rtl/cascade_intc.sv
module cascade_intc #(
  parameter logic [7:0] BASE_RST = 8'd32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] irq_in,
  input  logic        ack,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [7:0]  wr_data,
  output logic        irq_out,
  output logic [7:0]  vector
);
  localparam logic [15:0] CASC_BIT = 16'h0004;

  function automatic logic [3:0] first8(input logic [7:0] v);
    first8 = 4'd8;
    for (int i = 7; i >= 0; i--)
      if (v[i]) first8 = i[3:0];
  endfunction

  logic [15:0] irr, isr, msk, prev;
  logic [7:0]  base;
  logic        en;

  logic [7:0]  s_req, m_req;
  logic [3:0]  s_pick, s_top, m_pick, m_top, line;
  logic        s_int, m_int, take, eoi_m, eoi_s;
  logic [15:0] rise, take_set, take_clr, eoi_clr;

  assign s_req  = irr[15:8] & ~msk[15:8];
  assign s_pick = first8(s_req);
  assign s_top  = first8(isr[15:8]);
  assign s_int  = s_pick < s_top;

  assign m_req  = {irr[7:3], s_int, irr[1:0]} & ~msk[7:0];
  assign m_pick = first8(m_req);
  assign m_top  = first8(isr[7:0]);
  assign m_int  = m_pick < m_top;

  assign irq_out = en & m_int;
  assign line    = (m_pick == 4'd2) ? {1'b1, s_pick[2:0]} : m_pick;
  assign vector  = base + {4'd0, line};

  assign take  = ack & irq_out;
  assign eoi_m = wr_en && wr_addr == 3'd4;
  assign eoi_s = wr_en && wr_addr == 3'd5;

  assign rise     = irq_in & ~prev & ~CASC_BIT;
  assign take_clr = take ? (16'd1 << line) : 16'd0;
  assign take_set = take_clr | ((take && line[3]) ? CASC_BIT : 16'd0);
  assign eoi_clr  = ((eoi_m && !m_top[3]) ? (16'd1 << m_top) : 16'd0)
                  | ((eoi_s && !s_top[3]) ? (16'd1 << {1'b1, s_top[2:0]}) : 16'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr  <= '0;
      isr  <= '0;
      msk  <= '0;
      prev <= '0;
      base <= BASE_RST;
      en   <= 1'b0;
    end else begin
      prev <= irq_in;
      irr  <= (irr & ~take_clr) | rise;
      isr  <= (isr & ~eoi_clr) | take_set;
      if (wr_en) begin
        case (wr_addr)
          3'd0:    msk[7:0]  <= wr_data;
          3'd1:    msk[15:8] <= wr_data;
          3'd2:    base      <= wr_data;
          3'd3:    en        <= wr_data[0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cascade_intc_chk.sv
module cascade_intc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq_out,
  input logic        ack,
  input logic [7:0]  vector,
  input logic [7:0]  base,
  input logic [15:0] irr,
  input logic [15:0] isr,
  input logic        en
);
  a_r4_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !irq_out);

  a_r2_cascade_pin_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !irr[2]);

  a_r8_top_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    isr[0] |-> !irq_out);

  a_r7_ack_enters_service: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_out) |=> (isr != 16'd0));

  a_r6_vector_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (((vector - base) < 8'd16) && ((vector - base) != 8'd2)));
endmodule

bind cascade_intc cascade_intc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .ack(ack), .vector(vector),
  .base(base), .irr(irr), .isr(isr), .en(en)
);

// File: tb/cascade_intc_test.sv
`timescale 1ns/1ps
module cascade_intc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq = '0;
  logic        ack = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        irq_out;
  logic [7:0]  vector;

  cascade_intc uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq), .ack(ack), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .irq_out(irq_out), .vector(vector)
  );

  always #2 clk = ~clk;

  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R1";

  bit [15:0] q_irr, q_isr, q_msk, q_prev;
  int        q_base;
  bit        q_en;

  function automatic void model_eval(output bit irq_e, output int ln,
                                     output int mt, output int st);
    int sp = 8, mp = 8;
    bit req;
    st = 8; mt = 8;
    for (int k = 7; k >= 0; k--) begin
      if (q_isr[8+k]) st = k;
      if (q_irr[8+k] && !q_msk[8+k]) sp = k;
    end
    for (int k = 7; k >= 0; k--) begin
      if (q_isr[k]) mt = k;
      req = (k == 2) ? (sp < st) : q_irr[k];
      if (req && !q_msk[k]) mp = k;
    end
    irq_e = q_en && (mp < mt);
    ln = (mp == 2) ? 8 + sp : mp;
  endfunction

  always @(posedge clk) begin
    bit irq_e; int ln, mt, st;
    bit [15:0] nirr, nisr;
    if (!rst_n) begin
      q_irr = '0; q_isr = '0; q_msk = '0; q_prev = '0; q_base = 32; q_en = 0;
    end else begin
      model_eval(irq_e, ln, mt, st);
      nirr = q_irr; nisr = q_isr;
      if (wr_en && wr_addr == 3'd4 && mt < 8) nisr[mt] = 0;
      if (wr_en && wr_addr == 3'd5 && st < 8) nisr[8+st] = 0;
      if (ack && irq_e) begin
        nirr[ln] = 0; nisr[ln] = 1;
        if (ln >= 8) nisr[2] = 1;
      end
      for (int i = 0; i < 16; i++)
        if (i != 2 && irq[i] && !q_prev[i]) nirr[i] = 1;
      q_prev = irq;
      if (wr_en) begin
        case (wr_addr)
          3'd0: q_msk[7:0]  = wr_data;
          3'd1: q_msk[15:8] = wr_data;
          3'd2: q_base      = wr_data;
          3'd3: q_en        = wr_data[0];
          default: ;
        endcase
      end
      q_irr = nirr; q_isr = nisr;
    end
  end

  always @(negedge clk) begin
    bit irq_e; int ln, mt, st;
    int ev;
    if (rst_n) begin
      model_eval(irq_e, ln, mt, st);
      ev = (q_base + ln) % 256;
      checks++;
      if (irq_out !== irq_e) begin
        fails++;
        $display("FAIL %s irq_out actual=%0b expected=%0b t=%0t", cur_req, irq_out, irq_e, $time);
      end else if (irq_e && vector !== ev[7:0]) begin
        fails++;
        $display("FAIL %s vector actual=%0d expected=%0d t=%0t", cur_req, vector, ev, $time);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic do_ack;
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
  endtask

  task automatic line(input int i, input logic v);
    @(negedge clk); irq[i] = v;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // R1: output quiet while in reset and right after
    cyc(3);
    checks++;
    if (irq_out !== 1'b0) begin
      fails++; $display("FAIL R1 irq_out in reset actual=%0b expected=0", irq_out);
    end
    rst_n = 1;
    cyc(4);

    // R2: edge latch, held level, dead input 2
    cur_req = "R2";
    wr(3, 8'h01);
    line(5, 1); cyc(3);
    do_ack; wr(4, 0); cyc(4);
    line(2, 1); cyc(4); line(2, 0); line(5, 0); cyc(2);

    // R3: fixed order with secondary at slot 2
    cur_req = "R3";
    @(negedge clk); irq[6] = 1; irq[3] = 1; irq[12] = 1; irq[1] = 1;
    cyc(2);
    for (int n = 0; n < 4; n++) begin
      do_ack; cyc(1); wr(4, 0); wr(5, 0); cyc(1);
    end
    irq = '0; cyc(2);

    // R4: enable gates output and ack
    cur_req = "R4";
    wr(3, 8'h00);
    line(1, 1); cyc(3); do_ack; cyc(2);
    wr(3, 8'h01); cyc(2); do_ack; wr(4, 0); line(1, 0); cyc(2);

    // R5: masks retain, primary bit 2 covers secondary
    cur_req = "R5";
    wr(0, 8'h14);
    line(4, 1); line(9, 1); cyc(3);
    wr(0, 8'h10); cyc(2); do_ack; wr(4, 0); wr(5, 0);
    wr(0, 8'h00); cyc(2); do_ack; wr(4, 0); cyc(2);
    irq = '0; cyc(2);

    // R6: programmable base
    cur_req = "R6";
    wr(2, 8'h40);
    line(15, 1); cyc(2); do_ack; wr(4, 0); wr(5, 0);
    wr(2, 8'hF8);
    line(13, 1); cyc(2); do_ack; wr(4, 0); wr(5, 0);
    wr(2, 8'd32); irq = '0; cyc(2);

    // R7: ack with nothing pending is ignored
    cur_req = "R7";
    do_ack; cyc(2);
    line(7, 1); cyc(2); do_ack; cyc(2);

    // R8: line 7 in service; 6 nests, 7 again blocked
    cur_req = "R8";
    line(7, 0); line(7, 1); cyc(3);
    line(6, 1); cyc(2); do_ack; cyc(2);
    wr(4, 0); cyc(2); wr(4, 0); cyc(2); do_ack; wr(4, 0);
    irq = '0; cyc(2);

    // R9: secondary line needs both end-of-interrupt writes
    cur_req = "R9";
    line(10, 1); cyc(2); do_ack; cyc(1);
    wr(4, 0); line(11, 1); cyc(3);
    line(9, 1); cyc(2); do_ack; wr(4, 0); wr(5, 0); cyc(2);
    wr(5, 0); cyc(2); do_ack; wr(4, 0); wr(5, 0);
    irq = '0; cyc(2);

    // R3/R8/R9 mixed random traffic
    cur_req = "R3";
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      irq   = irq ^ (16'($urandom) & 16'($urandom) & 16'($urandom));
      ack   = ($urandom % 4) == 0;
      wr_en = ($urandom % 3) == 0;
      case ($urandom % 8)
        0: begin wr_addr = 3'd0; wr_data = 8'($urandom) & 8'($urandom); end
        1: begin wr_addr = 3'd1; wr_data = 8'($urandom) & 8'($urandom); end
        2: begin wr_addr = 3'd3; wr_data = 8'(($urandom % 8) != 0); end
        3, 4, 5: begin wr_addr = 3'd4; wr_data = 8'($urandom); end
        default: begin wr_addr = 3'd5; wr_data = 8'($urandom); end
      endcase
    end
    @(negedge clk); ack = 0; wr_en = 0;
    cyc(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule